// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit computes the memory address for a load or store in a pipeline with 16-bit instructions and 32-bit data. Each cycle it takes an addressing-mode code, a requested access size, the selected base register value, the R0 value, the global base register value, the current program counter and the raw displacement bits from the instruction. One clock later it presents the effective address, the access size that actually applies, a base-register update for the auto-modify modes, and a flag for addresses that break natural alignment.

Displacements are always zero-extended. In most modes they are scaled by the access width. The long-word PC-relative forms first round the PC down to a 4-byte boundary and then add the scaled offset and a fixed lookahead of 4. The block holds no architectural state. The register file, memory port and fetch logic sit outside it.

Mode codes (`mode`):

| Code | Mode |
|---|---|
| 0 | plain register-indirect |
| 1 | post-increment |
| 2 | pre-decrement |
| 3 | base plus short displacement |
| 4 | base plus R0 |
| 5 | GBR plus displacement |
| 6 | GBR plus R0 |
| 7 | PC-relative word |
| 8 | PC-relative long |
| 9 | PC-relative address only |
| 10 to 15 | unused |

Size codes (`size`, `acc_size`): 0 byte, 1 word (2 bytes), 2 long (4 bytes), 3 none.

Top module: `ls_addr_gen`

## Requirements
- R1: Mode 0 gives ea = base with wb_en low. Whenever wb_en is low, wb_value is zero. wb_en is high only for a valid input in mode 1 or 2.
- R2: Mode 1 gives ea = base, wb_en high and wb_value = base + step. The step is 1, 2 or 4 for byte, word or long. Arithmetic wraps modulo 2^32.
- R3: Mode 2 gives ea = wb_value = base - step, with wb_en high. Arithmetic wraps modulo 2^32.
- R4: Mode 3 gives ea = base + disp[3:0] × step. Displacement bits 7:4 are ignored.
- R5: Mode 4 gives ea = base + r0. Mode 6 gives ea = gbr + r0 and acc_size = 0 (byte), whatever the size input.
- R6: Mode 5 gives ea = gbr + disp[7:0] × step.
- R7: Mode 7 gives ea = pc + disp × 2 + 4 and acc_size = 1.
- R8: Mode 8 gives ea = (pc & 0xFFFFFFFC) + disp × 4 + 4 and acc_size = 2. Such an address is never misaligned.
- R9: Mode 9 gives the same address formula as mode 8, with acc_size = 3 and misaligned low.
- R10: misaligned is high when acc_size is 1 and ea[0] is 1, or when acc_size is 2 and ea[1:0] is nonzero. It is never high for byte or none.
- R11: Modes 10 to 15 give ea = 0, wb_en low, acc_size = 3 and misaligned low.
- R12: The outputs reflect the inputs of the previous clock. out_valid follows in_valid by one cycle. Reset clears every output to zero.
- R13: Size input code 3 in modes 0 to 5 behaves as byte (step 1, acc_size 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Requested access-size code |
| base | input | XLEN | Selected base register value |
| r0 | input | XLEN | R0 value |
| gbr | input | XLEN | Global base register value |
| pc | input | XLEN | Program counter of the instruction |
| disp | input | DISP_W | Raw displacement field |
| out_valid | output | 1 | Result valid |
| ea | output | XLEN | Effective address |
| acc_size | output | 2 | Access-size code that applies |
| wb_en | output | 1 | Base register update requested |
| wb_value | output | XLEN | New base register value |
| misaligned | output | 1 | Effective address misaligned for acc_size |

## Verification
A wrong mode decode or a wrong size scale shows up as a wrong ea or wb_value on the cycle after the request. Each request is compared against a full reference, so it is caught on the first vector that uses that mode. Random stimulus covers every mode and size code, including the size code 3. Directed vectors cover the wrapping corners at the top and bottom of the address space, the PC rounding with low bits set, and the ignored upper displacement bits. A stale pipeline register shows up as a mismatch with the previous vector one cycle later.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
   localparam logic [3:0] AM_IND     = 4'd0;
   localparam logic [3:0] AM_POSTINC = 4'd1;
   localparam logic [3:0] AM_PREDEC  = 4'd2;
   localparam logic [3:0] AM_BDISP   = 4'd3;
   localparam logic [3:0] AM_BIDX    = 4'd4;
   localparam logic [3:0] AM_GDISP   = 4'd5;
   localparam logic [3:0] AM_GIDX    = 4'd6;
   localparam logic [3:0] AM_PCW     = 4'd7;
   localparam logic [3:0] AM_PCL     = 4'd8;
   localparam logic [3:0] AM_PCA     = 4'd9;

   localparam logic [1:0] SZ_B    = 2'd0;
   localparam logic [1:0] SZ_W    = 2'd1;
   localparam logic [1:0] SZ_L    = 2'd2;
   localparam logic [1:0] SZ_NONE = 2'd3;

   function automatic logic [1:0] size_log2(input logic [1:0] s);
      case (s)
         SZ_W:    return 2'd1;
         SZ_L:    return 2'd2;
         default: return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/lsag_scale.sv
module lsag_scale #(
   parameter int IN_W = 8,
   parameter int XLEN = 32
) (
   input  logic [IN_W-1:0] d,
   input  logic [1:0]      lg,
   output logic [XLEN-1:0] y
);
   localparam int PAD = XLEN - IN_W;

   logic [XLEN-1:0] ext;
   assign ext = {{PAD{1'b0}}, d};
   assign y   = ext << lg;
endmodule

// File: rtl/lsag_align.sv
module lsag_align #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] addr,
   input  logic [1:0]      sz,
   output logic            bad
);
   import lsag_pkg::*;

   always_comb begin
      case (sz)
         SZ_W:    bad = addr[0];
         SZ_L:    bad = |addr[1:0];
         default: bad = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsag_calc.sv
module lsag_calc #(
   parameter int XLEN     = 32,
   parameter int DISP_W   = 8,
   parameter int SDISP_W  = 4,
   parameter int PC_AHEAD = 4
) (
   input  logic [3:0]        mode,
   input  logic [1:0]        size,
   input  logic [XLEN-1:0]   base,
   input  logic [XLEN-1:0]   r0,
   input  logic [XLEN-1:0]   gbr,
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic [XLEN-1:0]   ea,
   output logic [1:0]        eff_size,
   output logic              auto_mod,
   output logic [XLEN-1:0]   new_base
);
   import lsag_pkg::*;

   localparam logic [XLEN-1:0] AHEAD  = XLEN'(PC_AHEAD);
   localparam logic [XLEN-1:0] PCMASK = ~XLEN'(3);

   logic [1:0]      lg;
   logic [XLEN-1:0] step, off_short, off_long, off_pc4, pc_base4, dec_base;

   always_comb begin
      case (mode)
         AM_GIDX: eff_size = SZ_B;
         AM_PCW:  eff_size = SZ_W;
         AM_PCL:  eff_size = SZ_L;
         AM_IND, AM_POSTINC, AM_PREDEC, AM_BDISP, AM_BIDX, AM_GDISP:
                  eff_size = (size == SZ_NONE) ? SZ_B : size;
         default: eff_size = SZ_NONE;
      endcase
   end

   assign lg   = size_log2(eff_size);
   assign step = XLEN'(1) << lg;

   lsag_scale #(.IN_W(SDISP_W), .XLEN(XLEN)) u_sc_short (
      .d(disp[SDISP_W-1:0]), .lg(lg), .y(off_short));
   lsag_scale #(.IN_W(DISP_W), .XLEN(XLEN)) u_sc_long (
      .d(disp), .lg(lg), .y(off_long));
   lsag_scale #(.IN_W(DISP_W), .XLEN(XLEN)) u_sc_pc4 (
      .d(disp), .lg(2'd2), .y(off_pc4));

   assign pc_base4 = (pc & PCMASK) + AHEAD;
   assign dec_base = base - step;

   always_comb begin
      auto_mod = 1'b0;
      new_base = '0;
      case (mode)
         AM_IND:     ea = base;
         AM_POSTINC: begin
            ea       = base;
            auto_mod = 1'b1;
            new_base = base + step;
         end
         AM_PREDEC:  begin
            ea       = dec_base;
            auto_mod = 1'b1;
            new_base = dec_base;
         end
         AM_BDISP:   ea = base + off_short;
         AM_BIDX:    ea = base + r0;
         AM_GDISP:   ea = gbr + off_long;
         AM_GIDX:    ea = gbr + r0;
         AM_PCW:     ea = pc + off_long + AHEAD;
         AM_PCL,
         AM_PCA:     ea = pc_base4 + off_pc4;
         default:    ea = '0;
      endcase
   end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
   parameter int XLEN         = 32,
   parameter int DISP_W       = 8,
   parameter int SDISP_W      = 4,
   parameter int PC_AHEAD     = 4,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        mode,
   input  logic [1:0]        size,
   input  logic [XLEN-1:0]   base,
   input  logic [XLEN-1:0]   r0,
   input  logic [XLEN-1:0]   gbr,
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic              out_valid,
   output logic [XLEN-1:0]   ea,
   output logic [1:0]        acc_size,
   output logic              wb_en,
   output logic [XLEN-1:0]   wb_value,
   output logic              misaligned
);
   generate
      if (XLEN < 16)              $error("XLEN must be at least 16");
      if (SDISP_W > DISP_W)       $error("short displacement wider than long one");
      if (DISP_W + 2 > XLEN)      $error("scaled displacement exceeds XLEN");
      if (PC_AHEAD % 4 != 0)      $error("PC lookahead must keep long alignment");
   endgenerate

   logic [XLEN-1:0] c_ea, c_nb;
   logic [1:0]      c_sz;
   logic            c_auto, c_bad, c_wb;

   lsag_calc #(
      .XLEN(XLEN), .DISP_W(DISP_W), .SDISP_W(SDISP_W), .PC_AHEAD(PC_AHEAD)
   ) u_calc (
      .mode(mode), .size(size), .base(base), .r0(r0), .gbr(gbr), .pc(pc),
      .disp(disp), .ea(c_ea), .eff_size(c_sz), .auto_mod(c_auto),
      .new_base(c_nb)
   );

   lsag_align #(.XLEN(XLEN)) u_align (.addr(c_ea), .sz(c_sz), .bad(c_bad));

   assign c_wb = in_valid & c_auto;

   generate
      if (REGISTER_OUT) begin : g_reg
         logic              v_q, wb_q, bad_q;
         logic [XLEN-1:0]   ea_q, nb_q;
         logic [1:0]        sz_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q   <= 1'b0;
               wb_q  <= 1'b0;
               bad_q <= 1'b0;
               ea_q  <= '0;
               nb_q  <= '0;
               sz_q  <= '0;
            end else begin
               v_q   <= in_valid;
               wb_q  <= c_wb;
               bad_q <= c_bad;
               ea_q  <= c_ea;
               nb_q  <= c_wb ? c_nb : '0;
               sz_q  <= c_sz;
            end
         end
         assign out_valid  = v_q;
         assign wb_en      = wb_q;
         assign misaligned = bad_q;
         assign ea         = ea_q;
         assign wb_value   = nb_q;
         assign acc_size   = sz_q;
      end else begin : g_comb
         assign out_valid  = in_valid;
         assign wb_en      = c_wb;
         assign misaligned = c_bad;
         assign ea         = c_ea;
         assign wb_value   = c_wb ? c_nb : '0;
         assign acc_size   = c_sz;
      end
   endgenerate
endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
   parameter int XLEN         = 32,
   parameter bit REGISTER_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      mode,
   input logic [XLEN-1:0] base,
   input logic [XLEN-1:0] r0,
   input logic [XLEN-1:0] gbr,
   input logic            out_valid,
   input logic [XLEN-1:0] ea,
   input logic [1:0]      acc_size,
   input logic            wb_en,
   input logic [XLEN-1:0] wb_value,
   input logic            misaligned
);
   import lsag_pkg::*;

   logic [3:0]      m_q;
   logic [XLEN-1:0] b_q, r0_q, g_q, stp;

   generate
      if (REGISTER_OUT) begin : g_d
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               m_q <= '0; b_q <= '0; r0_q <= '0; g_q <= '0;
            end else begin
               m_q <= mode; b_q <= base; r0_q <= r0; g_q <= gbr;
            end
         end
      end else begin : g_n
         assign m_q = mode; assign b_q = base; assign r0_q = r0; assign g_q = gbr;
      end
   endgenerate

   assign stp = (acc_size == SZ_L) ? XLEN'(4) : (acc_size == SZ_W) ? XLEN'(2) : XLEN'(1);

   a_r1_wb_only_auto: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> out_valid && (m_q == AM_POSTINC || m_q == AM_PREDEC));
   a_r2_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && m_q == AM_POSTINC) |-> wb_en && ea == b_q && wb_value == ea + stp);
   a_r3_predec_match: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && m_q == AM_PREDEC) |-> wb_en && wb_value == ea && ea + stp == b_q);
   a_r5_gbr_index_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && m_q == AM_GIDX) |-> acc_size == SZ_B && ea == g_q + r0_q);
   a_r8_pcl_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && m_q == AM_PCL) |-> ea[1:0] == 2'b00 && !misaligned && acc_size == SZ_L);
   a_r10_narrow_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (acc_size == SZ_W || acc_size == SZ_L));
   a_r11_unused_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && m_q > AM_PCA) |-> ea == '0 && !wb_en && acc_size == SZ_NONE && !misaligned);
endmodule

bind ls_addr_gen lsag_chk #(.XLEN(XLEN), .REGISTER_OUT(REGISTER_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .base(base), .r0(r0), .gbr(gbr),
   .out_valid(out_valid), .ea(ea), .acc_size(acc_size), .wb_en(wb_en),
   .wb_value(wb_value), .misaligned(misaligned)
);

// File: tb/tb_ls_addr_gen.sv
module tb_ls_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  mode = '0;
   logic [1:0]  size = '0;
   logic [31:0] base = '0, r0 = '0, gbr = '0, pc = '0;
   logic [7:0]  disp = '0;
   logic        out_valid, wb_en, misaligned;
   logic [31:0] ea, wb_value;
   logic [1:0]  acc_size;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ls_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .size(size),
      .base(base), .r0(r0), .gbr(gbr), .pc(pc), .disp(disp),
      .out_valid(out_valid), .ea(ea), .acc_size(acc_size), .wb_en(wb_en),
      .wb_value(wb_value), .misaligned(misaligned)
   );

   function automatic string req_of(input logic [3:0] m, input logic [1:0] s);
      case (m)
         4'd0: return (s == 2'd3) ? "R13" : "R1";
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4, 4'd6: return "R5";
         4'd5: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         4'd9: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic reference(input logic [3:0] m, input logic [1:0] s,
                            output logic [31:0] x_ea, output logic [1:0] x_sz,
                            output logic x_wb, output logic [31:0] x_nb,
                            output logic x_bad);
      logic [1:0]  rs;
      logic [31:0] st;
      rs = (s == 2'd3) ? 2'd0 : s;
      st = (rs == 2'd2) ? 32'd4 : (rs == 2'd1) ? 32'd2 : 32'd1;
      x_wb = 1'b0; x_nb = 32'd0; x_sz = rs;
      case (m)
         4'd0: x_ea = base;
         4'd1: begin x_ea = base; x_wb = 1'b1; x_nb = base + st; end
         4'd2: begin x_ea = base - st; x_wb = 1'b1; x_nb = base - st; end
         4'd3: x_ea = base + {28'd0, disp[3:0]} * st;
         4'd4: x_ea = base + r0;
         4'd5: x_ea = gbr + {24'd0, disp} * st;
         4'd6: begin x_ea = gbr + r0; x_sz = 2'd0; end
         4'd7: begin x_ea = pc + {24'd0, disp} * 2 + 4; x_sz = 2'd1; end
         4'd8: begin x_ea = {pc[31:2], 2'b00} + {24'd0, disp} * 4 + 4; x_sz = 2'd2; end
         4'd9: begin x_ea = {pc[31:2], 2'b00} + {24'd0, disp} * 4 + 4; x_sz = 2'd3; end
         default: begin x_ea = 32'd0; x_sz = 2'd3; end
      endcase
      x_bad = (x_sz == 2'd1 && x_ea[0]) || (x_sz == 2'd2 && x_ea[1:0] != 2'b00);
   endtask

   task automatic apply(input logic [3:0] m, input logic [1:0] s, input logic [31:0] b,
                        input logic [31:0] rr, input logic [31:0] g, input logic [31:0] p,
                        input logic [7:0] d);
      logic [31:0] x_ea, x_nb;
      logic [1:0]  x_sz;
      logic        x_wb, x_bad;
      @(negedge clk);
      in_valid = 1'b1; mode = m; size = s; base = b; r0 = rr; gbr = g; pc = p; disp = d;
      reference(m, s, x_ea, x_sz, x_wb, x_nb, x_bad);
      @(negedge clk);
      checks++;
      if (!out_valid || ea !== x_ea || acc_size !== x_sz || wb_en !== x_wb ||
          wb_value !== x_nb || misaligned !== x_bad) begin
         errors++;
         $display("FAIL %s (R10 misalign, R12 valid) mode=%0d size=%0d: got v=%b ea=%h sz=%0d wb=%b nb=%h mis=%b exp v=1 ea=%h sz=%0d wb=%b nb=%h mis=%b",
                  req_of(m, s), m, s, out_valid, ea, acc_size, wb_en, wb_value, misaligned,
                  x_ea, x_sz, x_wb, x_nb, x_bad);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || ea !== 32'd0 || wb_en !== 1'b0 || wb_value !== 32'd0 ||
          acc_size !== 2'd0 || misaligned !== 1'b0) begin
         errors++;
         $display("FAIL R12 reset state: v=%b ea=%h wb=%b nb=%h sz=%0d mis=%b exp all zero",
                  out_valid, ea, wb_en, wb_value, acc_size, misaligned);
      end
      rst_n = 1'b1;

      // directed corners
      apply(4'd8, 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 8'hFF);      // R8 wrap and rounding
      apply(4'd9, 2'd1, 0, 0, 0, 32'h0000_1003, 8'h10);      // R9
      apply(4'd7, 2'd2, 0, 0, 0, 32'h0000_2001, 8'h03);      // R7 odd pc, misaligned R10
      apply(4'd2, 2'd2, 32'h0, 0, 0, 0, 0);                  // R3 wrap below zero
      apply(4'd1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);          // R2 wrap at top
      apply(4'd3, 2'd2, 32'h100, 0, 0, 0, 8'hF7);            // R4 upper disp bits ignored
      apply(4'd3, 2'd1, 32'h101, 0, 0, 0, 8'h02);            // R10 odd word address
      apply(4'd6, 2'd2, 0, 32'h3, 32'h1000, 0, 0);           // R5 forced byte
      apply(4'd5, 2'd2, 0, 0, 32'h4000, 0, 8'hFF);           // R6
      apply(4'd0, 2'd3, 32'h1235, 0, 0, 0, 0);               // R13 size 3 as byte
      apply(4'd12, 2'd1, 32'hDEAD_BEEF, 1, 1, 1, 8'h55);     // R11

      // R12: out_valid drops one cycle after in_valid
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || wb_en !== 1'b0) begin
         errors++;
         $display("FAIL R12 idle: v=%b wb=%b exp v=0 wb=0", out_valid, wb_en);
      end

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] b, rr, g, p;
         b = $urandom; rr = $urandom; g = $urandom; p = $urandom;
         if (($urandom % 3) == 0) b[1:0] = 2'b00;
         apply(4'($urandom % 16), 2'($urandom % 4), b, rr, g, p, 8'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule